// File: doc/BRIEF.md
# Power-On Watchdog Timer

This block is a down-counting watchdog that needs no software to start. When its power-on reset is released it begins counting from a built-in interval on a low-speed clock. That clock is independent of the bus clock. Its first timeout raises an interrupt flag. A second timeout, with the flag still set, raises a reset request pulse. Software keeps the system alive by writing the clear register before the second timeout.

Software reaches four write-only addresses on the bus clock: interval, control, clear and key. Every write to the interval, control or clear address must come straight after a write of the unlock key. The lock closes again once that single write is done. Accepted writes cross into the slow domain through a toggle handshake. While a transfer is in flight the bus side shows `busy`. The live count is driven out on `count_o` in the slow domain.

Top module: `pwr_wdog`

## Requirements
- R1: During and straight after reset, `count_o` equals the parameter INIT_LOAD (default 0x0000FFFF) and the interval register equals INIT_LOAD. Both enable bits are 1, `irq` and `wdog_rst` are 0, `locked` is 1 and `busy` is 0.
- R2: While the run enable is 1, `count_o` falls by one on every slow-clock cycle. In a cycle where it is 0, an underflow occurs and the count reloads the interval value, so one period lasts interval+1 cycles.
- R3: Write addresses are 0 interval, 1 control, 2 clear and 3 key. Writing 0x1ACCE551 to address 3 opens the lock (`locked`=0), and writing any other value to address 3 closes it. A write to address 0, 1 or 2 while locked has no effect. One accepted write to address 0, 1 or 2 closes the lock again.
- R4: An accepted write to the clear address, whatever its data, clears `irq` and restarts the count from the interval value.
- R5: An underflow with `irq` at 0 sets `irq`. An underflow with `irq` at 1 and the reset enable at 1 raises `wdog_rst`. With the reset enable at 0 the count only reloads.
- R6: Control data bit 0 is the run enable and bit 1 is the reset enable. While the run enable is 0 the count holds its value.
- R7: `wdog_rst` stays high for exactly RST_CYCLES slow cycles (default 4). After it rises the count is frozen, and every later command is ignored until the next slow-domain reset.
- R8: An accepted interval write loads the new value into both the interval register and the count. A data value of 0 is stored as 1.
- R9: After an accepted write to address 0, 1 or 2, `busy` is 1 from the next bus cycle until the slow side acknowledges. Writes to address 0, 1 or 2 made while `busy` is 1 are dropped and leave the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_lo | input | 1 | Low-speed count clock |
| rst_lo | input | 1 | Synchronous active-high power-on reset, slow domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 interval, 1 control, 2 clear, 3 key) |
| wr_data | input | 32 | Write data |
| busy | output | 1 | Transfer into the slow domain pending |
| locked | output | 1 | Lock closed |
| irq | output | 1 | Interrupt flag |
| wdog_rst | output | 1 | Reset request pulse |
| count_o | output | CNT_W | Current count (slow domain) |

## Verification
The assertions check on every cycle the following rules:
- the key opens the lock and one accepted write closes it;
- `busy` rises after each accepted write, and dropped writes leave the lock unchanged;
- `irq` rises only from a zero count;
- `wdog_rst` rises only when `irq` is already set;
- the count stays still while the pulse is high, and the pulse lasts its full length.

Some behaviours come only from the bench's scenarios:
- the exact countdown sequence from power-on;
- the reload value after each underflow;
- clamping of a zero interval;
- holding the count with the run enable off;
- firing no reset with the reset enable off;
- ignoring commands after the watchdog has fired.

// File: rtl/pwr_wdog_pkg.sv
package pwr_wdog_pkg;

    localparam int unsigned BUS_W = 32;
    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef enum logic [1:0] {
        ADR_LOAD  = 2'd0,
        ADR_CTRL  = 2'd1,
        ADR_CLEAR = 2'd2,
        ADR_KEY   = 2'd3
    } wd_addr_e;

    typedef enum logic [1:0] {
        CMD_LOAD  = 2'd0,
        CMD_CTRL  = 2'd1,
        CMD_CLEAR = 2'd2,
        CMD_NONE  = 2'd3
    } wd_cmd_e;

    typedef struct packed {
        wd_cmd_e          kind;
        logic [BUS_W-1:0] data;
    } wd_cmd_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_RST  = 2'd1,
        ST_HALT = 2'd2
    } wd_state_e;

    function automatic logic is_key(input logic [BUS_W-1:0] d);
        return d == UNLOCK_KEY;
    endfunction

endpackage

// File: rtl/pwr_wdog_sync.sv
module pwr_wdog_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_wdog_bus.sv
module pwr_wdog_bus
    import pwr_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             ack_s,
    output logic             req_tgl,
    output wd_cmd_t          cmd,
    output logic             busy,
    output logic             locked
);
    logic open_q;
    logic to_key;
    logic accept;

    assign busy   = req_tgl ^ ack_s;
    assign locked = ~open_q;
    assign to_key = wr_en && (wr_addr == ADR_KEY);
    assign accept = wr_en && (wr_addr != ADR_KEY) && open_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            req_tgl  <= 1'b0;
            cmd.kind <= CMD_NONE;
            cmd.data <= '0;
        end else if (to_key) begin
            open_q <= is_key(wr_data);
        end else if (accept) begin
            open_q   <= 1'b0;
            req_tgl  <= ~req_tgl;
            cmd.kind <= wd_cmd_e'(wr_addr);
            cmd.data <= wr_data;
        end
    end
endmodule

// File: rtl/pwr_wdog_core.sv
module pwr_wdog_core
    import pwr_wdog_pkg::*;
#(
    parameter int unsigned     CNT_W      = 32,
    parameter logic [CNT_W-1:0] INIT_LOAD = 'h0000_FFFF,
    parameter int unsigned     RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_s,
    input  wd_cmd_t          cmd,
    output logic             ack_tgl,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             wdog_rst
);
    localparam int unsigned RW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

    wd_state_e        state;
    logic [CNT_W-1:0] load_q;
    logic             run_en;
    logic             rst_en;
    logic [RW-1:0]    pulse_left;
    logic             new_cmd;
    logic [CNT_W-1:0] ld_raw;
    logic [CNT_W-1:0] ld_val;

    assign new_cmd  = req_s ^ ack_tgl;
    assign ld_raw   = cmd.data[CNT_W-1:0];
    assign ld_val   = (ld_raw == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : ld_raw;
    assign wdog_rst = (state == ST_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            load_q     <= INIT_LOAD;
            count      <= INIT_LOAD;
            run_en     <= 1'b1;
            rst_en     <= 1'b1;
            irq        <= 1'b0;
            pulse_left <= '0;
            ack_tgl    <= 1'b0;
        end else begin
            ack_tgl <= req_s;
            unique case (state)
                ST_RUN: begin
                    if (new_cmd) begin
                        unique case (cmd.kind)
                            CMD_LOAD: begin
                                load_q <= ld_val;
                                count  <= ld_val;
                            end
                            CMD_CTRL: begin
                                run_en <= cmd.data[0];
                                rst_en <= cmd.data[1];
                            end
                            CMD_CLEAR: begin
                                irq   <= 1'b0;
                                count <= load_q;
                            end
                            default: ;
                        endcase
                    end else if (run_en) begin
                        if (count == '0) begin
                            if (irq && rst_en) begin
                                state      <= ST_RST;
                                pulse_left <= RW'(RST_CYCLES - 1);
                            end else begin
                                irq   <= 1'b1;
                                count <= load_q;
                            end
                        end else begin
                            count <= count - 1'b1;
                        end
                    end
                end
                ST_RST: begin
                    if (pulse_left == '0) state <= ST_HALT;
                    else                  pulse_left <= pulse_left - 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwr_wdog.sv
module pwr_wdog
    import pwr_wdog_pkg::*;
#(
    parameter int unsigned      CNT_W       = 32,
    parameter logic [CNT_W-1:0] INIT_LOAD   = 'h0000_FFFF,
    parameter int unsigned      RST_CYCLES  = 4,
    parameter int unsigned      SYNC_STAGES = 2
) (
    input  logic             clk_bus,
    input  logic             rst_bus,
    input  logic             clk_lo,
    input  logic             rst_lo,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output logic             busy,
    output logic             locked,
    output logic             irq,
    output logic             wdog_rst,
    output logic [CNT_W-1:0] count_o
);
    logic    req_tgl;
    logic    req_s;
    logic    ack_tgl;
    logic    ack_s;
    wd_cmd_t cmd;

    pwr_wdog_bus bus_i (
        .clk     (clk_bus),
        .rst     (rst_bus),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ack_s   (ack_s),
        .req_tgl (req_tgl),
        .cmd     (cmd),
        .busy    (busy),
        .locked  (locked)
    );

    pwr_wdog_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk (clk_lo),
        .rst (rst_lo),
        .d   (req_tgl),
        .q   (req_s)
    );

    pwr_wdog_core #(
        .CNT_W      (CNT_W),
        .INIT_LOAD  (INIT_LOAD),
        .RST_CYCLES (RST_CYCLES)
    ) core_i (
        .clk      (clk_lo),
        .rst      (rst_lo),
        .req_s    (req_s),
        .cmd      (cmd),
        .ack_tgl  (ack_tgl),
        .count    (count_o),
        .irq      (irq),
        .wdog_rst (wdog_rst)
    );

    pwr_wdog_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk (clk_bus),
        .rst (rst_bus),
        .d   (ack_tgl),
        .q   (ack_s)
    );
endmodule

// File: rtl/pwr_wdog_chk.sv
module pwr_wdog_chk
    import pwr_wdog_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned RST_CYCLES = 4
) (
    input logic             clk_bus,
    input logic             rst_bus,
    input logic             clk_lo,
    input logic             rst_lo,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic             busy,
    input logic             locked,
    input logic             irq,
    input logic             wdog_rst,
    input logic [CNT_W-1:0] count_o
);
    int unsigned hi_cnt;

    always_ff @(posedge clk_lo) begin
        if (rst_lo)        hi_cnt <= 0;
        else if (wdog_rst) hi_cnt <= hi_cnt + 1;
        else               hi_cnt <= 0;
    end

    assert_key_opens_R3: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (wr_en && wr_addr == ADR_KEY && wr_data == UNLOCK_KEY) |=> !locked);

    assert_single_write_relock_R3: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (wr_en && wr_addr != ADR_KEY && !locked && !busy) |=> locked);

    assert_busy_after_write_R9: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (wr_en && wr_addr != ADR_KEY && !locked && !busy) |=> busy);

    assert_drop_keeps_lock_R9: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (wr_en && wr_addr != ADR_KEY && busy) |=> (locked == $past(locked)));

    assert_irq_from_zero_R5: assert property (@(posedge clk_lo) disable iff (rst_lo)
        $rose(irq) |-> ($past(count_o) == '0));

    assert_rst_needs_irq_R5: assert property (@(posedge clk_lo) disable iff (rst_lo)
        $rose(wdog_rst) |-> $past(irq));

    assert_frozen_in_pulse_R7: assert property (@(posedge clk_lo) disable iff (rst_lo)
        wdog_rst |=> $stable(count_o));

    assert_pulse_width_R7: assert property (@(posedge clk_lo) disable iff (rst_lo)
        $fell(wdog_rst) |-> (hi_cnt == RST_CYCLES));
endmodule

bind pwr_wdog pwr_wdog_chk #(
    .CNT_W      (CNT_W),
    .RST_CYCLES (RST_CYCLES)
) chk_i (
    .clk_bus  (clk_bus),
    .rst_bus  (rst_bus),
    .clk_lo   (clk_lo),
    .rst_lo   (rst_lo),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .locked   (locked),
    .irq      (irq),
    .wdog_rst (wdog_rst),
    .count_o  (count_o)
);

// File: tb/pwr_wdog_tb_top.sv
module pwr_wdog_tb_top;
    localparam int unsigned CNT_W = 32;
    localparam int unsigned INIT  = 20;
    localparam int unsigned RSTC  = 4;
    localparam logic [31:0] KEY   = 32'h1ACC_E551;

    logic             clk_bus = 1'b0;
    logic             clk_lo  = 1'b0;
    logic             rst_bus = 1'b1;
    logic             rst_lo  = 1'b1;
    logic             wr_en   = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [31:0]      wr_data = '0;
    logic             busy, locked, irq, wdog_rst;
    logic [CNT_W-1:0] count_o;

    int checks = 0;
    int fails  = 0;

    always #5  clk_bus = ~clk_bus;
    always #35 clk_lo  = ~clk_lo;

    pwr_wdog #(
        .CNT_W      (CNT_W),
        .INIT_LOAD  (32'(INIT)),
        .RST_CYCLES (RSTC)
    ) dut_i (
        .clk_bus  (clk_bus),
        .rst_bus  (rst_bus),
        .clk_lo   (clk_lo),
        .rst_lo   (rst_lo),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .locked   (locked),
        .irq      (irq),
        .wdog_rst (wdog_rst),
        .count_o  (count_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic slow(input int n);
        repeat (n) @(negedge clk_lo);
    endtask

    task automatic do_reset();
        rst_bus = 1'b1;
        rst_lo  = 1'b1;
        wr_en   = 1'b0;
        slow(3);
        @(negedge clk_bus) rst_bus = 1'b0;
        @(negedge clk_lo)  rst_lo  = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk_bus);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk_bus);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk_bus);
        slow(1);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] c0;
        bit saw;
        int hi;

        // Scenario A: power-on behaviour without software
        do_reset();
        check(count_o == INIT, "R1 count", count_o, INIT);
        check(irq == 0 && wdog_rst == 0, "R1 outputs", {irq, wdog_rst}, 0);
        check(locked == 1 && busy == 0, "R1 lock", {locked, busy}, 2);
        for (int k = 1; k <= INIT; k++) begin
            slow(1);
            check(count_o == INIT - k, "R2 countdown", count_o, INIT - k);
        end
        slow(1);
        check(irq == 1, "R5 first underflow irq", irq, 1);
        check(count_o == INIT, "R2 reload", count_o, INIT);
        slow(INIT);
        check(count_o == 0 && wdog_rst == 0, "R5 before second", {count_o, wdog_rst}, 0);
        slow(1);
        check(wdog_rst == 1, "R5 second underflow reset", wdog_rst, 1);
        hi = 0;
        while (wdog_rst && hi < 50) begin
            hi++;
            slow(1);
        end
        check(hi == RSTC, "R7 pulse width", hi, RSTC);
        bus_write(2'd3, KEY);
        bus_write(2'd2, 0);
        wait_idle();
        slow(10);
        check(count_o == 0 && irq == 1 && wdog_rst == 0, "R7 frozen",
              {count_o, irq, wdog_rst}, 2);

        // Scenario B: lock and clear
        do_reset();
        slow(INIT + 1);
        check(irq == 1, "R5 irq set", irq, 1);
        bus_write(2'd2, 0);
        check(busy == 0 && locked == 1, "R3 locked clear not issued", {busy, locked}, 1);
        slow(3);
        check(irq == 1, "R3 locked clear ignored", irq, 1);
        bus_write(2'd3, KEY);
        check(locked == 0, "R3 key opens", locked, 0);
        bus_write(2'd2, 32'hDEAD);
        check(busy == 1, "R9 busy after write", busy, 1);
        check(locked == 1, "R3 relock after one write", locked, 1);
        wait_idle();
        check(irq == 0, "R4 clear drops irq", irq, 0);
        check(count_o <= INIT && count_o >= INIT - 6, "R4 restart from load", count_o, INIT);
        bus_write(2'd3, KEY);
        bus_write(2'd3, 32'h1234_5678);
        check(locked == 1, "R3 wrong key relocks", locked, 1);

        // Scenario C: control, drop while busy, clamp
        do_reset();
        bus_write(2'd3, KEY);
        bus_write(2'd1, 32'h2);
        wait_idle();
        c0 = count_o;
        slow(INIT + 5);
        check(count_o == c0 && irq == 0, "R6 run disabled holds", count_o, c0);
        bus_write(2'd3, KEY);
        bus_write(2'd1, 32'h1);
        wait_idle();
        saw = 0;
        for (int k = 0; k < 3 * (INIT + 1) + 5; k++) begin
            slow(1);
            if (wdog_rst) saw = 1;
        end
        check(irq == 1 && !saw, "R6 reset disabled", {irq, saw}, 2);
        bus_write(2'd3, KEY);
        bus_write(2'd0, 32'd5);
        bus_write(2'd3, KEY);
        bus_write(2'd1, 32'h0);
        check(locked == 0, "R9 dropped write keeps unlock", locked, 0);
        wait_idle();
        check(count_o <= 5, "R8 load restarts count", count_o, 5);
        c0 = count_o;
        slow(1);
        check(count_o != c0, "R9 dropped control had no effect", count_o, c0);
        bus_write(2'd0, 32'd0);
        check(locked == 1, "R3 relock after load", locked, 1);
        wait_idle();
        saw = 0;
        for (int k = 0; k < 6; k++) begin
            if (count_o > 1) saw = 1;
            slow(1);
        end
        check(!saw, "R8 zero load clamped to one", saw, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule